// File: doc/BRIEF.md
# Reply Timeout Timer

This block turns a reply timeout, requested in microseconds, into a compact setting made of a 7-bit length and a 2-bit multiplier. The multiplier picks the size of the timer unit, and the length counts those units. The block keeps that setting in a register. It then runs a watchdog against a 1 µs tick. Once a request has finished on the channel, a start pulse arms the watchdog. If no reply-seen pulse arrives within length × unit microseconds, the block raises a one-cycle timeout pulse.

Each reprogram also reports the setting that was in force before the new one. That old setting is decoded back into microseconds, so the caller can restore it later. The tick comes from outside the block, and the block does not generate it.

Top module: `aux_reply_timer`

## Requirements
- R1: The multiplier codes 0, 1, 2 and 3 stand for units of 8, 16, 32 and 64 µs. The armed timer limit is length × unit ticks.
- R2: A nonzero request selects its multiplier by range: code 0 up to 1016 µs, code 1 up to 2032 µs, code 2 up to 4064 µs, and code 3 above 4064 µs.
- R3: The length is the request divided by the unit of the chosen range, rounded up when the division leaves a remainder. A nonzero request therefore never gives length 0.
- R4: The length saturates at 127.
- R5: A request of 0 µs loads the default setting, length 69 with multiplier 0. Reset also leaves that default in place, with prev_us_o at 0 and expired_o low.
- R6: The cycle after a load, prev_us_o shows the setting that was in force before that load, as length × unit in µs. The new length and multiplier show on len_o and mult_o in that same cycle.
- R7: After start_i, the block counts ticks. The tick that brings the count to the limit gives exactly one cycle of expired_o in the following cycle, and the timer then disarms.
- R8: reply_i disarms the timer. A reply in the same cycle as the final tick suppresses the timeout.
- R9: A start_i while the timer is armed restarts the count from zero, using the current setting.
- R10: With load_i low, len_o, mult_o and prev_us_o hold their values whatever cfg_us_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_us_i | input | US_W | Requested timeout in µs |
| load_i | input | 1 | Apply cfg_us_i |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| start_i | input | 1 | Request finished; arm the timer |
| reply_i | input | 1 | Reply start seen; disarm the timer |
| len_o | output | 7 | Encoded length in force |
| mult_o | output | 2 | Encoded multiplier in force |
| prev_us_o | output | 13 | Previous setting in µs, captured at the last load |
| expired_o | output | 1 | One-cycle timeout pulse |

## Verification
A fault in the encoder shows on len_o and mult_o in the cycle right after the load. It also shows in prev_us_o one load later, because the faulty value becomes the previous setting. A count or limit that is off by one moves expired_o by a whole tick, so a bench that samples after every tick sees it on the boundary tick. An arm flag that stays set after a reply or after expiry shows as a stray timeout, one full limit of ticks later.

// File: rtl/aux_tmo_pkg.sv
package aux_tmo_pkg;
  localparam int LEN_W      = 7;
  localparam int MUL_W      = 2;
  localparam int LEN_MAX    = 127;
  localparam int DEF_LEN    = 69;
  localparam int BASE_SHIFT = 3;                     // smallest unit is 8 us
  localparam int SPAN_US    = LEN_MAX << BASE_SHIFT; // 1016 us per range step
  localparam int PREV_W     = LEN_W + BASE_SHIFT + (1 << MUL_W) - 1;

  typedef struct packed {
    logic [MUL_W-1:0] mult;
    logic [LEN_W-1:0] len;
  } tmo_set_t;

  // length x unit, in microseconds
  function automatic logic [PREV_W-1:0] decode_us(input tmo_set_t s);
    return PREV_W'(32'(s.len) << (32'(s.mult) + BASE_SHIFT));
  endfunction
endpackage

// File: rtl/aux_tmo_setting.sv
module aux_tmo_setting
  import aux_tmo_pkg::*;
#(
  parameter int US_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [US_W-1:0]   req_us_i,
  output tmo_set_t          set_o,
  output logic [PREV_W-1:0] prev_us_o,
  output logic [PREV_W-1:0] limit_o
);
  localparam int NUM_RANGES = 1 << MUL_W;

  // choose the range, then take the ceiling of the division
  function automatic tmo_set_t encode(input logic [US_W-1:0] us);
    tmo_set_t r;
    int unsigned v, m, sh, q;
    v = 32'(us);
    r.mult = '0;
    r.len  = LEN_W'(DEF_LEN);
    if (v != 0) begin
      m = 0;
      for (int k = 0; k < NUM_RANGES - 1; k++)
        if (v > (SPAN_US << k)) m = k + 1;
      sh = m + BASE_SHIFT;
      q  = (v + (32'd1 << sh) - 32'd1) >> sh;
      if (q > LEN_MAX) q = LEN_MAX;
      r.mult = MUL_W'(m);
      r.len  = LEN_W'(q);
    end
    return r;
  endfunction

  tmo_set_t set_q;
  tmo_set_t set_next;
  logic [PREV_W-1:0] prev_q;

  assign set_next = encode(req_us_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q.mult <= '0;
      set_q.len  <= LEN_W'(DEF_LEN);
      prev_q     <= '0;
    end else if (load_i) begin
      prev_q <= decode_us(set_q);
      set_q  <= set_next;
    end
  end

  assign set_o     = set_q;
  assign prev_us_o = prev_q;
  assign limit_o   = decode_us(set_q);

  p_prev_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> prev_us_o == PREV_W'(32'($past(set_o.len)) << (32'($past(set_o.mult)) + 3)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(set_o) && $stable(prev_us_o));
  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_o.len != '0);
endmodule

// File: rtl/aux_tmo_counter.sv
module aux_tmo_counter
  import aux_tmo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              reply_i,
  input  logic [PREV_W-1:0] limit_i,
  output logic              expired_o
);
  logic              armed_q;
  logic [PREV_W-1:0] cnt_q;
  logic [PREV_W-1:0] limit_q;
  logic [PREV_W-1:0] cnt_next;
  logic              hit;
  logic              expired_q;

  assign cnt_next = cnt_q + 1'b1;
  assign hit      = armed_q && tick_i && (cnt_next == limit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      cnt_q     <= '0;
      limit_q   <= '0;
      expired_q <= 1'b0;
    end else begin
      expired_q <= hit && !start_i && !reply_i;
      if (start_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
        limit_q <= limit_i;
      end else if (reply_i || hit) begin
        armed_q <= 1'b0;
      end else if (armed_q && tick_i) begin
        cnt_q <= cnt_next;
      end
    end
  end

  assign expired_o = expired_q;

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |=> !expired_o);
  p_expire_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |-> $past(tick_i));
  p_reply_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reply_i |=> !expired_o);
  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !expired_o);
endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer
  import aux_tmo_pkg::*;
#(
  parameter int US_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [US_W-1:0] cfg_us_i,
  input  logic            load_i,
  input  logic            tick_i,
  input  logic            start_i,
  input  logic            reply_i,
  output logic [6:0]      len_o,
  output logic [1:0]      mult_o,
  output logic [12:0]     prev_us_o,
  output logic            expired_o
);
  tmo_set_t          cur_set;
  logic [PREV_W-1:0] limit;
  logic [PREV_W-1:0] prev_us;

  aux_tmo_setting #(.US_W(US_W)) u_setting (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .req_us_i  (cfg_us_i),
    .set_o     (cur_set),
    .prev_us_o (prev_us),
    .limit_o   (limit)
  );

  aux_tmo_counter u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .reply_i   (reply_i),
    .limit_i   (limit),
    .expired_o (expired_o)
  );

  assign len_o     = cur_set.len;
  assign mult_o    = cur_set.mult;
  assign prev_us_o = prev_us;
endmodule

// File: tb/aux_reply_timer_tb.sv
module aux_reply_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_us = '0;
  logic        load = 1'b0, tick = 1'b0, start = 1'b0, reply = 1'b0;
  logic [6:0]  len;
  logic [1:0]  mult;
  logic [12:0] prev_us;
  logic        expired;
  int errors = 0, checks = 0;
  int cur_l = 69, cur_m = 0;

  always #4 clk = ~clk;

  aux_reply_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_us_i(cfg_us), .load_i(load), .tick_i(tick),
    .start_i(start), .reply_i(reply), .len_o(len), .mult_o(mult),
    .prev_us_o(prev_us), .expired_o(expired)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int us, output int l, output int m);
    int unit;
    if (us == 0) begin l = 69; m = 0; end
    else begin
      m = 0;
      while (m < 3 && us > 1016 * (1 << m)) m++;
      unit = 8 * (1 << m);
      l = us / unit + ((us % unit) != 0 ? 1 : 0);
      if (l > 127) l = 127;
    end
  endfunction

  task automatic do_load(input int us);
    @(negedge clk); cfg_us = 16'(us); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 reset len", len, 69);
    chk("R5 reset mult", mult, 0);
    chk("R5 reset prev", prev_us, 0);
    chk("R5 reset expired", expired, 0);
  endtask

  task automatic t_encode(input string req, input int us);
    int l, m;
    model(us, l, m);
    do_load(us);
    chk({req, " len"}, len, l);
    chk({req, " mult"}, mult, m);
    chk("R6 prev", prev_us, cur_l * (8 << cur_m));
    cur_l = l; cur_m = m;
  endtask

  task automatic t_expire(input int us);
    int l, m, lim, seen;
    t_encode("R3", us);
    model(us, l, m);
    lim = l * (8 << m);
    pulse_start();
    seen = 0;
    for (int i = 0; i < lim - 1; i++) begin
      tick_once();
      if (expired) seen++;
      @(negedge clk);
    end
    chk("R7 no early expiry", seen, 0);
    tick_once();
    chk("R1 R7 expiry at limit", expired, 1);
    @(negedge clk);
    chk("R7 single pulse", expired, 0);
    seen = 0;
    for (int i = 0; i < lim + 2; i++) begin tick_once(); if (expired) seen++; end
    chk("R7 disarmed after expiry", seen, 0);
  endtask

  task automatic t_reply();
    int seen = 0;
    t_encode("R3", 8);
    pulse_start();
    for (int i = 0; i < 3; i++) tick_once();
    @(negedge clk); reply = 1'b1;
    @(negedge clk); reply = 1'b0;
    for (int i = 0; i < 12; i++) begin tick_once(); if (expired) seen++; end
    chk("R8 reply cancels", seen, 0);
    pulse_start();
    for (int i = 0; i < 7; i++) tick_once();
    @(negedge clk); tick = 1'b1; reply = 1'b1;
    @(negedge clk); tick = 1'b0; reply = 1'b0;
    chk("R8 reply on final tick", expired, 0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin tick_once(); if (expired) seen++; end
    chk("R8 stays disarmed", seen, 0);
  endtask

  task automatic t_restart();
    int seen = 0;
    pulse_start();
    for (int i = 0; i < 7; i++) tick_once();
    pulse_start();
    for (int i = 0; i < 7; i++) begin tick_once(); if (expired) seen++; end
    chk("R9 restart from zero", seen, 0);
    tick_once();
    chk("R9 expiry after restart", expired, 1);
  endtask

  task automatic t_hold();
    int l0 = len, m0 = mult, p0 = prev_us;
    @(negedge clk); cfg_us = 16'd3000;
    repeat (3) @(negedge clk);
    chk("R10 len held", len, l0);
    chk("R10 mult held", mult, m0);
    chk("R10 prev held", prev_us, p0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_encode("R2", 1016);
    t_encode("R2", 1017);
    t_encode("R2", 2032);
    t_encode("R2", 2033);
    t_encode("R2", 4064);
    t_encode("R2", 4065);
    t_encode("R3", 20);
    t_encode("R3", 5000);
    t_encode("R4", 10000);
    t_encode("R5", 0);
    t_encode("R3", 1);
    t_expire(20);
    t_expire(17);
    t_reply();
    t_restart();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule